// File: doc/BRIEF.md
# Output Compare PWM Channel

This block is a parameterised timer with one compare channel. A counter steps on a count-enable strobe from an outside prescaler. It runs in one of three ways: upward from 0 to a reload limit, downward from the limit to 0, or up and down between the two in a triangle. The channel compares the count with a compare value and drives a reference waveform. An eight-way mode selects how it does this: hold, set on match, clear on match, toggle on match, forced low, forced high, or one of two pulse-width shapes.

The reload limit and the compare value each have a shadow register. When preloading is on, a write lands in the shadow and becomes active only at the next update event. An update event happens when the counter wraps, or when the update-generate pulse arrives. The update-generate pulse also restarts the counter. A single-shot option stops the counter at its next wrap. Two output pins are driven from the reference: one follows it and the other follows its inverse. Each pin has its own polarity, its own enable, and its own level for when it is disabled.

Top module: `oc_pwm_timer`

## Requirements
- R1: With `align`=0 and `count_down_sel`=0, each `tick` while running raises `count` by one. A tick at a count of at least the active limit returns it to 0, and `update_evt` pulses in the following cycle.
- R2: With `align`=0 and `count_down_sel`=1, each tick lowers `count` by one. A tick at 0 reloads the active limit, and `update_evt` pulses.
- R3: With `align`=1, 2 or 3 and a limit A of at least 1, the count goes 0,1..A,A-1..1,0,1 and so on, with period 2A. `dir_is_down` is 1 while the count falls. `update_evt` pulses after the tick that leaves A going up and after the tick that leaves 0 going down.
- R4: The count holds whenever `tick` is 0 or the counter is not running. `start` sets running and `halt` clears it.
- R5: `oc_mode` 0 holds `oc_ref`. Codes 1, 2 and 3 set, clear or invert `oc_ref` one cycle after a counting tick at which `count` equals the active compare value. Code 4 drives `oc_ref` low and code 5 drives it high.
- R6: `oc_ref` follows the count with one cycle of latency. Code 6 (shape A) gives high when count < compare while rising, and count <= compare while falling. Code 7 (shape B) gives high when count >= compare while rising, and count > compare while falling.
- R7: `cmp_hit` pulses one cycle after a counting tick at which count equals compare. This is filtered by direction: in edge mode (`align`=0) and in `align`=3 every match counts, `align`=1 keeps only falling matches, and `align`=2 keeps only rising matches.
- R8: With `arr_preload` or `cmp_preload` set, a write takes effect only at the next update event. With the preload bit clear, a write takes effect at once.
- R9: `upd_gen` loads both shadows into the active registers. It sets the count to the limit when counting down in edge mode and to 0 otherwise, sets the direction to rising, and pulses `update_evt` next cycle.
- R10: With `one_shot` set, the wrap that raises an update event clears `running`, and the count then stays put.
- R11: Each pin is its idle level when its enable is 0. Otherwise `out_true` = `oc_ref` XOR `pol_true` and `out_comp` = NOT `oc_ref` XOR `pol_comp`.
- R12: After reset, `count`, `oc_ref`, `cmp_hit`, `update_evt` and `running` are 0, and both limit and compare registers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable strobe from the prescaler |
| start | input | 1 | Set the running state |
| halt | input | 1 | Clear the running state |
| one_shot | input | 1 | Stop at the next wrap |
| count_down_sel | input | 1 | Edge-mode direction, 1 = down |
| align | input | 2 | 0 edge, 1..3 triangle with flag filter |
| arr_preload | input | 1 | Limit writes go through the shadow |
| arr_wr | input | 1 | Limit write strobe |
| arr_wdata | input | CNT_W | Limit write value |
| cmp_preload | input | 1 | Compare writes go through the shadow |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | CNT_W | Compare write value |
| upd_gen | input | 1 | Software update pulse |
| oc_mode | input | 3 | Reference mode code |
| pol_true | input | 1 | Invert the true pin |
| pol_comp | input | 1 | Invert the complementary pin |
| en_true | input | 1 | Enable the true pin |
| en_comp | input | 1 | Enable the complementary pin |
| idle_true | input | 1 | True pin level when disabled |
| idle_comp | input | 1 | Complementary pin level when disabled |
| count | output | CNT_W | Counter value |
| dir_is_down | output | 1 | Current direction, 1 = falling |
| running | output | 1 | Counter running state |
| update_evt | output | 1 | One-cycle update event pulse |
| oc_ref | output | 1 | Reference waveform |
| cmp_hit | output | 1 | Filtered compare-match pulse |
| out_true | output | 1 | True output pin |
| out_comp | output | 1 | Complementary output pin |

## Verification
The assertions assume `upd_gen` never arrives in the same cycle as a limit write. They also assume `start` is not raised in the cycle of a single-shot wrap. The stimulus keeps these apart by giving writes, `upd_gen` and `start` each their own cycle. The triangle checks assume a limit of at least 1, and the sweep uses limits from 1 to 4 with compare values from 0 to one past the limit. Expected counts, directions, match pulses and references are derived from the tick index by modular arithmetic.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [2:0] {
        OC_FROZEN   = 3'd0,
        OC_SET      = 3'd1,
        OC_CLEAR    = 3'd2,
        OC_TOGGLE   = 3'd3,
        OC_FORCE_LO = 3'd4,
        OC_FORCE_HI = 3'd5,
        OC_PWM_A    = 3'd6,
        OC_PWM_B    = 3'd7
    } oc_mode_e;

    typedef enum logic [1:0] {
        ALIGN_EDGE   = 2'd0,
        ALIGN_C_DOWN = 2'd1,
        ALIGN_C_UP   = 2'd2,
        ALIGN_C_BOTH = 2'd3
    } align_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             halt_i,
    input  logic             one_shot_i,
    input  logic             dir_down_i,
    input  logic [1:0]       align_i,
    input  logic             arr_pre_i,
    input  logic             arr_wr_i,
    input  logic [CNT_W-1:0] arr_wdata_i,
    input  logic             ugen_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             down_o,
    output logic             active_o,
    output logic             upd_o,
    output logic             load_o
);
    import pwm_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] arr_sh;
        logic [CNT_W-1:0] arr_act;
        logic             down;
        logic             active;
        logic             upd;
    } tb_state_t;

    tb_state_t q, d;
    logic      wrap;
    logic      edge_mode;
    logic [CNT_W-1:0] next_arr;

    assign edge_mode = (align_e'(align_i) == ALIGN_EDGE);
    assign next_arr  = arr_pre_i ? q.arr_sh : q.arr_act;

    always_comb begin
        d      = q;
        d.upd  = 1'b0;
        wrap   = 1'b0;
        load_o = 1'b0;
        if (arr_wr_i) begin
            d.arr_sh = arr_wdata_i;
            if (!arr_pre_i) d.arr_act = arr_wdata_i;
        end
        if (start_i) d.active = 1'b1;
        if (halt_i)  d.active = 1'b0;
        if (ugen_i) begin
            d.arr_act = q.arr_sh;
            d.cnt     = (edge_mode && dir_down_i) ? q.arr_sh : '0;
            d.down    = 1'b0;
            d.upd     = 1'b1;
            load_o    = 1'b1;
        end else if (tick_i && q.active) begin
            if (!edge_mode) begin
                if (!q.down) begin
                    if (q.cnt >= q.arr_act) begin
                        wrap = 1'b1;
                        if (q.arr_act == '0) begin
                            d.cnt = '0;
                        end else begin
                            d.cnt  = q.arr_act - ONE;
                            d.down = 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + ONE;
                    end
                end else begin
                    if (q.cnt == '0) begin
                        wrap   = 1'b1;
                        d.down = 1'b0;
                        d.cnt  = (q.arr_act == '0) ? '0 : ONE;
                    end else begin
                        d.cnt = q.cnt - ONE;
                    end
                end
            end else if (dir_down_i) begin
                if (q.cnt == '0) begin
                    wrap  = 1'b1;
                    d.cnt = next_arr;
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end else begin
                if (q.cnt >= q.arr_act) begin
                    wrap  = 1'b1;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            if (wrap) begin
                d.upd  = 1'b1;
                load_o = 1'b1;
                if (arr_pre_i)  d.arr_act = q.arr_sh;
                if (one_shot_i) d.active  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o    = q.cnt;
    assign down_o   = edge_mode ? dir_down_i : q.down;
    assign active_o = q.active;
    assign upd_o    = q.upd;

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !ugen_i) |=> $stable(q.cnt)) else $error("count moved without tick"); // R4
    AST_ONE_SHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && one_shot_i && !start_i) |=> !q.active) else $error("single shot kept running"); // R10
    AST_EDGE_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && !dir_down_i && tick_i && q.active && !ugen_i && !arr_wr_i && q.cnt < q.arr_act)
        |=> q.cnt == $past(q.cnt) + ONE) else $error("up count step wrong"); // R1
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             down_i,
    input  logic [1:0]       align_i,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic             load_i,
    input  logic             cmp_pre_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    input  logic [2:0]       mode_i,
    output logic             ref_o,
    output logic             hit_o
);
    import pwm_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cmp_sh;
        logic [CNT_W-1:0] cmp_act;
        logic             ref_lvl;
        logic             hit;
    } cmp_state_t;

    cmp_state_t q, d;
    oc_mode_e   md;
    align_e     al;
    logic       ev;
    logic       dir_ok;

    assign md = oc_mode_e'(mode_i);
    assign al = align_e'(align_i);
    assign ev = tick_i && active_i && (cnt_i == q.cmp_act);

    always_comb begin
        case (al)
            ALIGN_C_DOWN: dir_ok = down_i;
            ALIGN_C_UP:   dir_ok = !down_i;
            default:      dir_ok = 1'b1;
        endcase
    end

    always_comb begin
        d     = q;
        d.hit = ev && dir_ok;
        if (cmp_wr_i) begin
            d.cmp_sh = cmp_wdata_i;
            if (!cmp_pre_i) d.cmp_act = cmp_wdata_i;
        end
        if (load_i && cmp_pre_i) d.cmp_act = q.cmp_sh;
        case (md)
            OC_SET:      if (ev) d.ref_lvl = 1'b1;
            OC_CLEAR:    if (ev) d.ref_lvl = 1'b0;
            OC_TOGGLE:   if (ev) d.ref_lvl = !q.ref_lvl;
            OC_FORCE_LO: d.ref_lvl = 1'b0;
            OC_FORCE_HI: d.ref_lvl = 1'b1;
            OC_PWM_A:    d.ref_lvl = down_i ? (cnt_i <= q.cmp_act) : (cnt_i <  q.cmp_act);
            OC_PWM_B:    d.ref_lvl = down_i ? (cnt_i >  q.cmp_act) : (cnt_i >= q.cmp_act);
            default:     d.ref_lvl = q.ref_lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ref_o = q.ref_lvl;
    assign hit_o = q.hit;

    AST_HIT_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        q.hit |-> ($past(cnt_i) == $past(q.cmp_act))) else $error("hit without match"); // R7
    AST_FORCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (md == OC_FORCE_LO) |=> !q.ref_lvl) else $error("forced low not low"); // R5
    AST_SHAPE_A_RISING: assert property (@(posedge clk) disable iff (!rst_n)
        (md == OC_PWM_A && !down_i && cnt_i >= q.cmp_act) |=> !q.ref_lvl) else $error("shape A high"); // R6
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
    parameter int NPIN = 2
) (
    input  logic [NPIN-1:0] lvl_i,
    input  logic [NPIN-1:0] pol_i,
    input  logic [NPIN-1:0] en_i,
    input  logic [NPIN-1:0] idle_i,
    output logic [NPIN-1:0] pin_o
);
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign pin_o[g] = en_i[g] ? (lvl_i[g] ^ pol_i[g]) : idle_i[g];
    end
endmodule

// File: rtl/oc_pwm_timer.sv
module oc_pwm_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             halt,
    input  logic             one_shot,
    input  logic             count_down_sel,
    input  logic [1:0]       align,
    input  logic             arr_preload,
    input  logic             arr_wr,
    input  logic [CNT_W-1:0] arr_wdata,
    input  logic             cmp_preload,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             upd_gen,
    input  logic [2:0]       oc_mode,
    input  logic             pol_true,
    input  logic             pol_comp,
    input  logic             en_true,
    input  logic             en_comp,
    input  logic             idle_true,
    input  logic             idle_comp,
    output logic [CNT_W-1:0] count,
    output logic             dir_is_down,
    output logic             running,
    output logic             update_evt,
    output logic             oc_ref,
    output logic             cmp_hit,
    output logic             out_true,
    output logic             out_comp
);
    localparam int NPIN = 2;

    logic            load;
    logic [NPIN-1:0] pins;

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start), .halt_i(halt),
        .one_shot_i(one_shot), .dir_down_i(count_down_sel), .align_i(align),
        .arr_pre_i(arr_preload), .arr_wr_i(arr_wr), .arr_wdata_i(arr_wdata),
        .ugen_i(upd_gen), .cnt_o(count), .down_o(dir_is_down), .active_o(running),
        .upd_o(update_evt), .load_o(load)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cnt_i(count), .down_i(dir_is_down), .align_i(align),
        .tick_i(tick), .active_i(running), .load_i(load), .cmp_pre_i(cmp_preload),
        .cmp_wr_i(cmp_wr), .cmp_wdata_i(cmp_wdata), .mode_i(oc_mode),
        .ref_o(oc_ref), .hit_o(cmp_hit)
    );

    pwm_outstage #(.NPIN(NPIN)) u_out (
        .lvl_i({~oc_ref, oc_ref}), .pol_i({pol_comp, pol_true}),
        .en_i({en_comp, en_true}), .idle_i({idle_comp, idle_true}), .pin_o(pins)
    );

    assign out_true = pins[0];
    assign out_comp = pins[1];

    AST_COMP_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_true && en_comp && (pol_true == pol_comp)) |-> (out_true != out_comp))
        else $error("pins not complementary"); // R11
endmodule

// File: tb/tb_oc_pwm_timer.sv
module tb_oc_pwm_timer;
    localparam int W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick = 0, start = 0, halt = 0, one_shot = 0, count_down_sel = 0;
    logic [1:0] align = 0;
    logic arr_preload = 0, arr_wr = 0, cmp_preload = 0, cmp_wr = 0, upd_gen = 0;
    logic [W-1:0] arr_wdata = 0, cmp_wdata = 0;
    logic [2:0] oc_mode = 0;
    logic pol_true = 0, pol_comp = 0, en_true = 0, en_comp = 0, idle_true = 0, idle_comp = 0;
    logic [W-1:0] count;
    logic dir_is_down, running, update_evt, oc_ref, cmp_hit, out_true, out_comp;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    oc_pwm_timer #(.CNT_W(W)) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int f_cnt(int k, int a, int kind);
        int p;
        if (kind == 0) return k % (a + 1);
        if (kind == 1) return a - (k % (a + 1));
        p = k % (2 * a);
        return (p <= a) ? p : 2 * a - p;
    endfunction

    function automatic bit f_dn(int k, int a, int kind);
        int p;
        if (kind == 0) return 1'b0;
        if (kind == 1) return 1'b1;
        p = k % (2 * a);
        return (p > a) || (p == 0 && k > 0);
    endfunction

    task automatic wait_cnt(input int v);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (int'(count) == v) break;
        end
    endtask

    // kind: 0 edge up, 1 edge down, 2 triangle with align cm
    task automatic run_cfg(input int a, input int c, input int kind, input int cm,
                           input int m, input int nt);
        bit exp_ref, prep_hi, up_ok, hit_exp, wrp;
        int pc, cur;
        bit pd;
        prep_hi = (m == 2 || m == 0);
        @(negedge clk);
        tick = 0; halt = 1; one_shot = 0; arr_preload = 0; cmp_preload = 0;
        count_down_sel = (kind == 1); align = (kind == 2) ? 2'(cm) : 2'd0;
        arr_wr = 1; arr_wdata = W'(a); cmp_wr = 1; cmp_wdata = W'(c);
        oc_mode = prep_hi ? 3'd5 : 3'd4;
        @(negedge clk);
        halt = 0; arr_wr = 0; cmp_wr = 0; upd_gen = 1;
        @(negedge clk);
        upd_gen = 0; start = 1; oc_mode = 3'(m);
        chk(int'(count) == f_cnt(0, a, kind), "R9 reinit count", count, f_cnt(0, a, kind));
        chk(update_evt == 1'b1, "R9 update pulse", update_evt, 1);
        @(negedge clk);
        start = 0; tick = 1;
        exp_ref = prep_hi;
        for (int k = 1; k <= nt; k++) begin
            @(negedge clk);
            pc = f_cnt(k - 1, a, kind);
            pd = f_dn(k - 1, a, kind);
            cur = f_cnt(k, a, kind);
            if (kind == 0)      wrp = (pc == a);
            else if (kind == 1) wrp = (pc == 0);
            else                wrp = (pc == a && !pd) || (pc == 0 && pd);
            case (kind)
                0: chk(int'(count) == cur && update_evt == wrp, "R1 up count/update", count, cur);
                1: chk(int'(count) == cur && update_evt == wrp, "R2 down count/update", count, cur);
                default: begin
                    chk(int'(count) == cur && update_evt == wrp, "R3 triangle count/update", count, cur);
                    chk(dir_is_down == f_dn(k, a, kind), "R3 direction", dir_is_down, f_dn(k, a, kind));
                end
            endcase
            case (m)
                1: if (pc == c) exp_ref = 1;
                2: if (pc == c) exp_ref = 0;
                3: if (pc == c) exp_ref = ~exp_ref;
                4: exp_ref = 0;
                5: exp_ref = 1;
                6: exp_ref = pd ? (pc <= c) : (pc < c);
                7: exp_ref = pd ? (pc > c) : (pc >= c);
                default: ;
            endcase
            if (m >= 6) chk(oc_ref == exp_ref, "R6 shape reference", oc_ref, exp_ref);
            else        chk(oc_ref == exp_ref, "R5 mode reference", oc_ref, exp_ref);
            up_ok = (kind != 2) || (cm == 3) || (cm == 1 && pd) || (cm == 2 && !pd);
            hit_exp = (pc == c) && up_ok;
            chk(cmp_hit == hit_exp, "R7 match flag", cmp_hit, hit_exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int exp_seq;
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk(count == 0 && running == 0, "R12 count/running", count, 0);
        chk(oc_ref == 0 && cmp_hit == 0 && update_evt == 0, "R12 ref/flags", oc_ref, 0);
        chk(out_true == 0 && out_comp == 0, "R12 pins idle", out_true, 0);

        for (int a = 1; a <= 4; a++)
            for (int c = 0; c <= a + 1; c++)
                for (int m = 0; m < 8; m++) begin
                    run_cfg(a, c, 0, 0, m, 2 * (a + 1) + 2);
                    run_cfg(a, c, 1, 0, m, 2 * (a + 1) + 2);
                    for (int cm = 1; cm <= 3; cm++) run_cfg(a, c, 2, cm, m, 4 * a + 2);
                end

        // R8 limit preload: old limit kept until the wrap
        run_cfg(3, 1, 0, 0, 6, 1);
        arr_preload = 1;
        wait_cnt(1);
        arr_wr = 1; arr_wdata = 6;
        for (int j = 1; j <= 11; j++) begin
            @(negedge clk);
            arr_wr = 0;
            exp_seq = (j <= 2) ? 1 + j : (j - 3) % 7;
            chk(int'(count) == exp_seq, "R8 preloaded limit", count, exp_seq);
        end
        // R8 limit written directly
        arr_preload = 0;
        wait_cnt(1);
        arr_wr = 1; arr_wdata = 2;
        for (int j = 1; j <= 5; j++) begin
            @(negedge clk);
            arr_wr = 0;
            chk(int'(count) == (1 + j) % 3, "R8 direct limit", count, (1 + j) % 3);
        end
        // R8 compare preload (limit 2, compare 1 -> 2)
        cmp_preload = 1;
        wait_cnt(0);
        cmp_wr = 1; cmp_wdata = 2;
        @(negedge clk);
        cmp_wr = 0;
        if (count != 2) wait_cnt(2);
        chk(oc_ref == 0, "R8 compare held before update", oc_ref, 0);
        wait_cnt(0);
        wait_cnt(2);
        chk(oc_ref == 1, "R8 compare loaded at update", oc_ref, 1);
        cmp_preload = 0;

        // R10 single shot
        run_cfg(3, 1, 0, 0, 6, 1);
        one_shot = 1;
        @(negedge clk); @(negedge clk);
        chk(count == 3, "R10 before wrap", count, 3);
        @(negedge clk);
        chk(count == 0 && running == 0, "R10 stopped at wrap", running, 0);
        repeat (4) @(negedge clk);
        chk(count == 0, "R10 count stays", count, 0);
        one_shot = 0;

        // R4 tick gating and halt
        run_cfg(4, 1, 0, 0, 6, 2);
        tick = 0;
        held = count;
        repeat (5) @(negedge clk);
        chk(int'(count) == held, "R4 hold without tick", count, held);
        tick = 1; halt = 1;
        @(negedge clk);
        halt = 0;
        held = count;
        repeat (4) @(negedge clk);
        chk(int'(count) == held && running == 0, "R4 hold when halted", count, held);
        tick = 0;

        // R11 pin shaping, all combinations
        for (int r = 0; r < 2; r++) begin
            @(negedge clk);
            oc_mode = r ? 3'd5 : 3'd4;
            @(negedge clk);
            for (int s = 0; s < 64; s++) begin
                bit et, ec;
                @(negedge clk);
                {pol_true, en_true, idle_true, pol_comp, en_comp, idle_comp} = 6'(s);
                #1;
                et = en_true ? (r[0] ^ pol_true) : idle_true;
                ec = en_comp ? (~r[0] ^ pol_comp) : idle_comp;
                chk(out_true == et, "R11 true pin", out_true, et);
                chk(out_comp == ec, "R11 comp pin", out_comp, ec);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule